// File: doc/BRIEF.md
# Execute-Stage ALU with Condition Codes

This block is the execute stage of a small 32-bit processor core. Each cycle it takes two operands, an operation code and a function code, and produces a result word without delay. When the operation code selects the arithmetic and logic group and the set-flags enable is high, it also loads a three-bit condition-code register with zero, sign and overflow at the next clock edge.

For every other operation code the block adds the two operands. Address, displacement and stack-pointer arithmetic all go through this path, and the flags stay untouched. For conditional jumps it evaluates the branch decision without delay from the stored flags, using signed-compare meaning.

Register-file access, memory access and instruction fetch are outside the block. The reset is synchronous and active low.

Top module: `exec_alu_cc`

## Requirements
- R1: With operation code 0x6 and function code 0, `result` equals `opnd_b + opnd_a` modulo 2^32 in the same cycle.
- R2: With operation code 0x6 and function code 1, `result` equals `opnd_b - opnd_a`, so the first operand is taken from the second.
- R3: With operation code 0x6, function code 2 gives `opnd_a & opnd_b` and function code 3 gives `opnd_a ^ opnd_b`.
- R4: On a flag update, `flags_q` (bit 2 zero, bit 1 sign, bit 0 overflow) takes zero = (result == 0) and sign = result bit 31 at the next rising edge.
- R5: Overflow is set for an add when both operands share a sign and the result's sign differs. It is set for a subtract when the operand signs differ and the result's sign differs from `opnd_b`. It is always cleared for AND and XOR.
- R6: `flags_q` changes only when operation code is 0x6, function code is 0 to 3 and `flag_en` is high. Otherwise it holds its value.
- R7: For any operation code other than 0x6, `result` equals `opnd_a + opnd_b`, for example a displacement or a -4 stack adjustment.
- R8: With operation code 0x6 and function code 4 to 15, `bad_op` is 1, `result` is 0 and the flags hold. `bad_op` is 0 for every other input.
- R9: With operation code 0x7, `jump_take` follows the function code using less = sign xor overflow. The codes are: 0 always; 1 less or zero; 2 less; 3 zero; 4 not zero; 5 not less; 6 not less and not zero.
- R10: `jump_take` is 0 whenever operation code is not 0x7, or function code is 7 to 15.
- R11: A clock edge with `rst_n` low sets `flags_q` to 3'b100 (zero=1, sign=0, overflow=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 4 | Operation code (0x6 arithmetic/logic, 0x7 jump, others address add) |
| fcode | input | 4 | Function code |
| flag_en | input | 1 | Allows an arithmetic/logic operation to load the flags |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (minuend for subtract) |
| result | output | 32 | Result word |
| flags_q | output | 3 | Stored flags {zero, sign, overflow} |
| jump_take | output | 1 | Branch decision for the current jump |
| bad_op | output | 1 | Undefined function code in the arithmetic group |

## Verification
The branch decision depends only on stored flags, so the hardest case to reach is a jump evaluated against flags holding overflow without sign. In that state the plain sign and the signed "less" disagree. The stimulus first runs a subtract of a positive value from the most negative word, which leaves sign 0 and overflow 1, and then sweeps every jump function code. The bench does the same for an add overflow that leaves sign and overflow both set, and for the zero-only and sign-only states.

// File: rtl/alu_cc_pkg.sv
// Package: shared encodings and types for the execute-stage ALU.
// Assumes a 4-bit operation code and 4-bit function code from decode.
package alu_cc_pkg;

    localparam logic [3:0] OPC_ARITH = 4'h6;
    localparam logic [3:0] OPC_JUMP  = 4'h7;

    typedef enum logic [3:0] {
        FN_ADD = 4'h0,
        FN_SUB = 4'h1,
        FN_AND = 4'h2,
        FN_XOR = 4'h3
    } arith_fn_e;

    typedef enum logic [3:0] {
        JC_ALWAYS = 4'h0,
        JC_LE     = 4'h1,
        JC_LT     = 4'h2,
        JC_EQ     = 4'h3,
        JC_NE     = 4'h4,
        JC_GE     = 4'h5,
        JC_GT     = 4'h6
    } jump_cond_e;

    typedef struct packed {
        logic zf;
        logic sf;
        logic of;
    } cc_t;

    localparam cc_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_datapath.sv
// Module: combinational datapath. One shared adder serves add, subtract
// and address arithmetic; the logic unit serves AND and XOR.
// Assumes opcode/fcode are stable during the cycle; no state inside.
module alu_datapath
    import alu_cc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   opcode,
    input  logic [3:0]   fcode,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output cc_t          cc_next,
    output logic         arith_ok,
    output logic         arith_bad
);
    localparam int MSB = W - 1;

    logic          is_arith;
    logic          do_sub;
    logic [W-1:0]  addend;
    logic [W-1:0]  sum;
    logic          sum_ovf;

    // Decode the group and pick subtract mode for the shared adder.
    always_comb begin
        is_arith  = (opcode == OPC_ARITH);
        arith_ok  = is_arith && (fcode <= 4'(FN_XOR));
        arith_bad = is_arith && (fcode >  4'(FN_XOR));
        do_sub    = is_arith && (fcode == 4'(FN_SUB));
    end

    // Shared adder: b + a, or b + ~a + 1 for subtract.
    always_comb begin
        addend = do_sub ? ~opnd_a : opnd_a;
        sum    = opnd_b + addend + W'(do_sub);
        // Same rule serves add and subtract once the addend is inverted.
        sum_ovf = (addend[MSB] == opnd_b[MSB]) && (sum[MSB] != opnd_b[MSB]);
    end

    // Select the result word for the current operation.
    always_comb begin
        result = sum;
        if (is_arith) begin
            unique case (fcode)
                4'(FN_ADD), 4'(FN_SUB): result = sum;
                4'(FN_AND):             result = opnd_a & opnd_b;
                4'(FN_XOR):             result = opnd_a ^ opnd_b;
                default:                result = '0;
            endcase
        end
    end

    // Candidate flags; logic operations always clear overflow.
    always_comb begin
        cc_next.zf = (result == '0);
        cc_next.sf = result[MSB];
        cc_next.of = (fcode == 4'(FN_ADD) || fcode == 4'(FN_SUB)) ? sum_ovf : 1'b0;
    end

endmodule

// File: rtl/cc_register.sv
// Module: condition-code register with synchronous active-low reset.
// Assumes load is only raised for a valid arithmetic/logic operation.
module cc_register
    import alu_cc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  cc_t  cc_d,
    output cc_t  cc_q
);
    // Hold flags, reload on a qualified operation, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cc_q <= CC_RESET;
        else if (load)
            cc_q <= cc_d;
    end

endmodule

// File: rtl/branch_eval.sv
// Module: jump condition evaluation from stored flags, signed meaning.
// Assumes the jump function code arrives with the jump operation code.
module branch_eval
    import alu_cc_pkg::*;
(
    input  logic       is_jump,
    input  logic [3:0] fcode,
    input  cc_t        cc,
    output logic       take
);
    logic lt;

    // Decode the jump function code against the flags.
    always_comb begin
        lt   = cc.sf ^ cc.of;
        take = 1'b0;
        if (is_jump) begin
            case (fcode)
                4'(JC_ALWAYS): take = 1'b1;
                4'(JC_LE):     take = lt | cc.zf;
                4'(JC_LT):     take = lt;
                4'(JC_EQ):     take = cc.zf;
                4'(JC_NE):     take = ~cc.zf;
                4'(JC_GE):     take = ~lt;
                4'(JC_GT):     take = ~lt & ~cc.zf;
                default:       take = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/exec_alu_cc.sv
// Module: execute-stage top. Combinational result and branch decision,
// registered condition codes. Assumes operands are already read from the
// register file and that jump operands are ignored here.
module exec_alu_cc
    import alu_cc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   opcode,
    input  logic [3:0]   fcode,
    input  logic         flag_en,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic [2:0]   flags_q,
    output logic         jump_take,
    output logic         bad_op
);
    cc_t  cc_next;
    cc_t  cc_q;
    logic arith_ok;
    logic cc_load;

    alu_datapath #(.W(W)) i_dp (
        .opcode    (opcode),
        .fcode     (fcode),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .cc_next   (cc_next),
        .arith_ok  (arith_ok),
        .arith_bad (bad_op)
    );

    // Only a defined arithmetic/logic operation with enable loads flags.
    always_comb cc_load = arith_ok && flag_en;

    cc_register i_cc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cc_load),
        .cc_d  (cc_next),
        .cc_q  (cc_q)
    );

    branch_eval i_br (
        .is_jump (opcode == OPC_JUMP),
        .fcode   (fcode),
        .cc      (cc_q),
        .take    (jump_take)
    );

    // Present the flags as a flat vector {zero, sign, overflow}.
    always_comb flags_q = cc_q;

endmodule

// File: rtl/exec_alu_cc_checker.sv
// Module: assertion checker bound to exec_alu_cc; observes ports only.
module exec_alu_cc_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   opcode,
    input logic [3:0]   fcode,
    input logic         flag_en,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic [2:0]   flags_q,
    input logic         jump_take,
    input logic         bad_op
);
    logic upd;
    always_comb upd = (opcode == 4'h6) && (fcode < 4'h4) && flag_en;

    assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(flags_q));

    assert_zero_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (flags_q[2] == ($past(result) == '0)) && (flags_q[1] == $past(result[W-1])));

    assert_logic_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && fcode[1]) |=> !flags_q[0]);

    assert_bad_fn_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == 4'h6) && (fcode > 4'h3)) |-> (bad_op && result == '0));

    assert_no_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != 4'h7 || fcode > 4'h6) |-> !jump_take);

    assert_addr_add_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != 4'h6) |-> (result == opnd_a + opnd_b));

    assert_reset_flags_R11: assert property (@(posedge clk)
        !rst_n |=> (flags_q == 3'b100));

endmodule

bind exec_alu_cc exec_alu_cc_checker #(.W(W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .fcode     (fcode),
    .flag_en   (flag_en),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .flags_q   (flags_q),
    .jump_take (jump_take),
    .bad_op    (bad_op)
);

// File: tb/test_exec_alu_cc.sv
`timescale 1ns/1ps
module test_exec_alu_cc;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  opcode, fcode;
    logic        flag_en;
    logic [31:0] opnd_a, opnd_b;
    logic [31:0] result;
    logic [2:0]  flags_q;
    logic        jump_take, bad_op;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    exec_alu_cc i_exec_alu_cc (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .fcode(fcode),
        .flag_en(flag_en), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .result(result), .flags_q(flags_q), .jump_take(jump_take), .bad_op(bad_op)
    );

    // {fcode, a, b, expected result, expected {Z,S,O}}
    localparam int NV = 10;
    localparam logic [102:0] VECS [NV] = '{
        {4'h0, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 3'b000},
        {4'h0, 32'h0000_0001, 32'h7fff_ffff, 32'h8000_0000, 3'b011},
        {4'h0, 32'h0000_0001, 32'hffff_ffff, 32'h0000_0000, 3'b100},
        {4'h1, 32'h0000_0005, 32'h0000_0003, 32'hffff_fffe, 3'b010},
        {4'h1, 32'h0000_0001, 32'h8000_0000, 32'h7fff_ffff, 3'b001},
        {4'h1, 32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 3'b100},
        {4'h2, 32'hf0f0_f0f0, 32'hff00_ff00, 32'hf000_f000, 3'b010},
        {4'h3, 32'h1234_5678, 32'h1234_5678, 32'h0000_0000, 3'b100},
        {4'h0, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 3'b101},
        {4'h3, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000, 3'b010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic exp_take(input int fn, input logic z, input logic s, input logic o);
        case (fn)
            0: return 1'b1;
            1: return (s ^ o) | z;
            2: return s ^ o;
            3: return z;
            4: return !z;
            5: return !(s ^ o);
            6: return !(s ^ o) && !z;
            default: return 1'b0;
        endcase
    endfunction

    // Drive an operation at the falling edge; outputs settle 1 ns later.
    task automatic drive(input logic [3:0] op, input logic [3:0] fn,
                         input logic [31:0] a, input logic [31:0] b, input logic en);
        @(negedge clk);
        opcode = op; fcode = fn; opnd_a = a; opnd_b = b; flag_en = en;
        #1;
    endtask

    // Let the pending edge load the flags, then compare.
    task automatic flags_after_edge(input string req, input logic [2:0] exp);
        @(posedge clk); #1;
        check(req, 32'(flags_q), 32'(exp));
    endtask

    task automatic sweep_jumps(input logic [2:0] fl);
        for (int fn = 0; fn < 8; fn++) begin
            drive(4'h7, 4'(fn), 32'h0, 32'h0, 1'b1);
            check(fn == 7 ? "R10 jump code 7" : "R9 jump decision",
                  32'(jump_take), 32'(exp_take(fn, fl[2], fl[1], fl[0])));
        end
    endtask

    task automatic set_flags(input logic [31:0] a, input logic [31:0] b,
                             input logic [3:0] fn, input logic [2:0] fl);
        drive(4'h6, fn, a, b, 1'b1);
        flags_after_edge("R5 flag setup", fl);
    endtask

    initial begin
        rst_n = 1'b0; opcode = 4'h1; fcode = 4'h0; flag_en = 1'b0;
        opnd_a = '0; opnd_b = '0;
        repeat (2) @(posedge clk);
        #1;
        check("R11 reset flags", 32'(flags_q), 32'h4);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: result same cycle, flags after the edge.
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  vf;
            logic [31:0] va, vb, vr;
            logic [2:0]  vfl;
            {vf, va, vb, vr, vfl} = VECS[i];
            drive(4'h6, vf, va, vb, 1'b1);
            check(vf == 4'h0 ? "R1 add" : vf == 4'h1 ? "R2 sub" : "R3 logic", result, vr);
            check("R8 bad_op low on valid", 32'(bad_op), 32'h0);
            flags_after_edge(vf[1] ? "R4 logic flags" : "R5 arith flags", vfl);
        end

        // Flags now 3'b010. Enable low: result still computed, flags held.
        drive(4'h6, 4'h0, 32'h0000_0001, 32'h7fff_ffff, 1'b0);
        check("R1 add without flag update", result, 32'h8000_0000);
        flags_after_edge("R6 flag_en low holds", 3'b010);

        // Address arithmetic on other operation codes.
        drive(4'h4, 4'h0, 32'h0000_001c, 32'h0000_0100, 1'b1);
        check("R7 displacement add", result, 32'h0000_011c);
        flags_after_edge("R6 memory op holds", 3'b010);
        drive(4'ha, 4'h0, 32'hffff_fffc, 32'h0000_0100, 1'b1);
        check("R7 stack adjust", result, 32'h0000_00fc);
        check("R10 no jump on other opcode", 32'(jump_take), 32'h0);
        flags_after_edge("R6 stack op holds", 3'b010);

        // Undefined arithmetic function code.
        drive(4'h6, 4'h5, 32'h3, 32'h3, 1'b1);
        check("R8 bad_op high", 32'(bad_op), 32'h1);
        check("R8 result zero", result, 32'h0);
        flags_after_edge("R8 flags held", 3'b010);

        // Jump sweeps over distinct flag states.
        sweep_jumps(3'b010);
        set_flags(32'h5, 32'h5, 4'h1, 3'b100);
        sweep_jumps(3'b100);
        set_flags(32'h3, 32'h5, 4'h1, 3'b000);
        sweep_jumps(3'b000);
        set_flags(32'h1, 32'h8000_0000, 4'h1, 3'b001);
        sweep_jumps(3'b001);
        set_flags(32'h1, 32'h7fff_ffff, 4'h0, 3'b011);
        sweep_jumps(3'b011);

        drive(4'h6, 4'h0, 32'h0, 32'h0, 1'b0);
        check("R10 no jump on arith opcode", 32'(jump_take), 32'h0);

        // Synchronous reset mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R11 reset mid-run", 32'(flags_q), 32'h4);
        @(negedge clk);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule